// File: doc/BRIEF.md
# PCI configuration access engine

This block converts one configuration-space request into a single non-prefetch transaction on a simple address/command/data bus that feeds a PCI initiator. A request names the bus, device, function and register offset, the access size in bytes, a read/write flag and the write data. The engine encodes the bus address for a type 0 cycle (bus 0) or a type 1 cycle (any other bus), derives active-low byte enables from the size and the low offset bits, shifts write data onto its byte lanes, and after the transaction checks the initiator's sticky master-abort flag.

Read data comes back shifted down to bit 0 and masked to the access size. A master abort is cleared with a one-cycle clear pulse and reported as device-not-found. A workaround input makes reads repeat: the command is reissued for eight rounds, read data is sampled twice per round, and only the last sample is kept. Requests use a valid/ready handshake, and each request gets exactly one response pulse carrying a status code.

Top module: `pci_cfg_engine`

## Requirements
- R1: With bus number 0 the bus address is `(1 << (32 - dev))` truncated to 32 bits, OR'd with function in [10:8] and register offset bits [7:2] in [7:2]. Bits [1:0] are 00, and device 0 sets no select bit.
- R2: With a nonzero bus number the bus address is bus in [23:16], device in [15:11], function in [10:8], offset bits [7:2] in [7:2], bit 1 = 0 and bit 0 = 1.
- R3: `bus_cmd[7:4]` holds active-low byte enables, where n = offset mod 4. Size 1 clears only lane n. Size 2 clears lanes n and n+1. Size 4 clears all four. `bus_cmd[3:0]` is 4'hA for a read and 4'hB for a write.
- R4: A size other than 1, 2 or 4, or a size of 2 at n = 3, gets status 1 (bad register) and read data all ones. No `bus_strobe` is issued.
- R5: Write data is driven on `bus_wdata` shifted left by 8×n bits.
- R6: A successful read returns `bus_rdata` shifted right by 8×n and masked to 8, 16 or 32 bits by size. A successful write returns data 0.
- R7: If `abort_flag` is set after the transaction, the engine pulses `abort_clear` for one cycle and responds with status 2 (device not found) and data all ones.
- R8: A read issues exactly one strobe when `workaround` is low. When `workaround` was high at acceptance, it issues 8 strobes, and the result comes from the data returned by the last strobe. A write always issues one strobe, and strobes are never back to back.
- R9: `req_ready` is high only while idle. Each accepted request produces exactly one single-cycle `rsp_valid`, during which `req_ready` is low. Status 0 means success.
- R10: `bus_addr`, `bus_cmd` and `bus_wdata` stay stable from acceptance to the response. `busy` is high during the response cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, right-aligned |
| workaround | input | 1 | Repeated-read mode |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 bad register, 2 device not found |
| rsp_rdata | output | 32 | Aligned read data |
| busy | output | 1 | Request in progress |
| bus_strobe | output | 1 | Issue one transaction |
| bus_addr | output | 32 | Encoded bus address |
| bus_cmd | output | 8 | Byte enables and command code |
| bus_wdata | output | 32 | Lane-shifted write data |
| bus_rdata | input | 32 | Data returned by the initiator |
| abort_flag | input | 1 | Sticky master-abort indication |
| abort_clear | output | 1 | Write-one-to-clear pulse for the abort flag |

## Verification
The response cycle and the arrival of the next request can fall in the same cycle. The bench raises `req_valid` for a new request in the very cycle it sees `rsp_valid`. The engine must hold `req_ready` low then and accept the request only after it returns to idle. This is judged by the strobe count of each transaction and by a per-cycle monitor that flags any cycle with `rsp_valid` and `req_ready` both high. The abort clear and a workaround reissue also interact, because the abort flag stays set across the eight rounds. The bench drives aborting reads in workaround mode and expects a single clear pulse and a device-not-found response.

// File: rtl/pci_cfg_engine.sv
module pci_cfg_engine #(
  parameter int ROUNDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_func,
  input  logic [7:0]  req_reg,
  input  logic [2:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  input  logic        workaround,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [31:0] rsp_rdata,
  output logic        busy,
  output logic        bus_strobe,
  output logic [31:0] bus_addr,
  output logic [7:0]  bus_cmd,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        abort_flag,
  output logic        abort_clear
);
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_SAMP, S_CHECK, S_RESP} state_t;
  state_t state;

  logic [1:0]    n, n_q;
  logic [2:0]    size_q;
  logic          wr_q, wa_q, phase;
  logic [RW-1:0] round;
  logic [31:0]   rdata_q, mask, aligned;
  logic          size_ok;
  logic [3:0]    be;
  logic [32:0]   sel;
  logic [31:0]   addr_new;

  assign n = req_reg[1:0];
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd4) ||
                   (req_size == 3'd2 && n != 2'd3);

  always_comb begin
    case (req_size)
      3'd1:    be = ~(4'b0001 << n);
      3'd2:    be = ~(4'b0011 << n);
      default: be = 4'b0000;
    endcase
  end

  assign sel = 33'd1 << (6'd32 - {1'b0, req_dev});
  assign addr_new = (req_bus == 8'd0)
      ? (sel[31:0] | {21'd0, req_func, req_reg[7:2], 2'b00})
      : {8'd0, req_bus, req_dev, req_func, req_reg[7:2], 2'b01};

  assign mask = (size_q == 3'd1) ? 32'h0000_00ff :
                (size_q == 3'd2) ? 32'h0000_ffff : 32'hffff_ffff;
  assign aligned = (rdata_q >> {n_q, 3'b000}) & mask;

  assign req_ready   = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign bus_strobe  = (state == S_ISSUE);
  assign rsp_valid   = (state == S_RESP);
  assign abort_clear = (state == S_CHECK) && abort_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      n_q        <= '0;
      size_q     <= '0;
      wr_q       <= 1'b0;
      wa_q       <= 1'b0;
      phase      <= 1'b0;
      round      <= '0;
      rdata_q    <= '0;
      bus_addr   <= '0;
      bus_cmd    <= '0;
      bus_wdata  <= '0;
      rsp_status <= 2'd0;
      rsp_rdata  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          n_q       <= n;
          size_q    <= req_size;
          wr_q      <= req_write;
          wa_q      <= workaround;
          phase     <= 1'b0;
          round     <= '0;
          bus_addr  <= addr_new;
          bus_cmd   <= {be, req_write ? 4'hB : 4'hA};
          bus_wdata <= req_wdata << {n, 3'b000};
          if (!size_ok) begin
            rsp_status <= 2'd1;
            rsp_rdata  <= '1;
            state      <= S_RESP;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= wr_q ? S_CHECK : S_SAMP;
        S_SAMP: begin
          rdata_q <= bus_rdata;
          if (!wa_q) state <= S_CHECK;
          else if (!phase) phase <= 1'b1;
          else begin
            phase <= 1'b0;
            if (round == LAST) state <= S_CHECK;
            else begin
              round <= round + 1'b1;
              state <= S_ISSUE;
            end
          end
        end
        S_CHECK: begin
          if (abort_flag) begin
            rsp_status <= 2'd2;
            rsp_rdata  <= '1;
          end else begin
            rsp_status <= 2'd0;
            rsp_rdata  <= wr_q ? 32'd0 : aligned;
          end
          state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(req_ready)) |->
      ($stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata)));
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  no_accept_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R7
  clear_to_nodev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clear |=> (rsp_valid && rsp_status == 2'd2 && rsp_rdata == 32'hffff_ffff));
  // R4
  bad_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size == 3'd3 || req_size == 3'd0)) |=>
      (!bus_strobe && rsp_valid && rsp_status == 2'd1));
  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe);
endmodule

// File: tb/test_pci_cfg_engine.sv
module test_pci_cfg_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_bus = '0, req_reg = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0, req_size = '0;
  logic req_write = 1'b0, workaround = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, busy, bus_strobe, abort_clear;
  logic [1:0] rsp_status;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [7:0] bus_cmd;
  logic [31:0] bus_rdata;
  logic abort_flag;

  int tests = 0, fails = 0;
  int scnt, base;
  logic [31:0] cap_addr, cap_wd;
  logic [7:0] cap_cmd;
  logic drift, seen_rsp;

  always #4 clk = ~clk;

  pci_cfg_engine i_pci_cfg_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .workaround(workaround), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .busy(busy), .bus_strobe(bus_strobe),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .abort_flag(abort_flag), .abort_clear(abort_clear));

  function automatic logic [31:0] mix(input logic [31:0] a, input int c);
    return a ^ (32'(c) * 32'h9E37_79B9);
  endfunction

  function automatic logic absent(input logic [31:0] a);
    return a[0] ? (a[15:11] == 5'd7 || a[15:11] == 5'd19) : (a[25] || a[13]);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [7:0] r);
    logic [63:0] s;
    s = 64'd1 << (32 - int'(d));
    if (b == 8'd0) return s[31:0] | (32'(f) << 8) | (32'(r) & 32'hfc);
    return (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | (32'(r) & 32'hfc) | 32'd1;
  endfunction

  function automatic logic [3:0] exp_be(input int n, input int sz);
    if (sz == 1) return 4'(~(1 << n));
    if (sz == 2) return 4'(~(3 << n));
    return 4'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      scnt <= 0; bus_rdata <= '0; abort_flag <= 1'b0; drift <= 1'b0;
      cap_addr <= '0; cap_cmd <= '0; cap_wd <= '0;
    end else begin
      if (bus_strobe) begin
        if (scnt != base && (bus_addr != cap_addr || bus_cmd != cap_cmd)) drift <= 1'b1;
        scnt      <= scnt + 1;
        bus_rdata <= mix(bus_addr, scnt + 1);
        cap_addr  <= bus_addr;
        cap_cmd   <= bus_cmd;
        cap_wd    <= bus_wdata;
        if (absent(bus_addr)) abort_flag <= 1'b1;
      end else if (abort_clear) abort_flag <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (seen_rsp) chk(!busy && req_ready, "R10 busy low after response", {31'd0, busy}, 32'd0);
      if (rsp_valid) chk(busy && !req_ready, "R9 ready low during response", {31'd0, req_ready}, 32'd0);
    end
    seen_rsp = rst_n && rsp_valid;
  end

  task automatic do_txn(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [7:0] r, input logic [2:0] sz, input logic wr,
                        input logic [31:0] wd, input logic wa);
    int n, ns;
    logic bad, ab;
    logic [31:0] ea, raw, mk, edata;
    n   = int'(r[1:0]);
    bad = !(sz == 1 || sz == 4 || (sz == 2 && n != 3));
    ab  = !bad && (d == 5'd7 || d == 5'd19);
    ns  = bad ? 0 : (wr ? 1 : (wa ? 8 : 1));
    ea  = exp_addr(b, d, f, r);
    req_bus = b; req_dev = d; req_func = f; req_reg = r; req_size = sz;
    req_write = wr; req_wdata = wd; workaround = wa; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    base = scnt;
    drift = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    mk  = (sz == 1) ? 32'hff : (sz == 2) ? 32'hffff : 32'hffff_ffff;
    raw = mix(ea, base + ns);
    if (bad || ab) edata = 32'hffff_ffff;
    else if (wr) edata = 32'd0;
    else edata = (raw >> (8 * n)) & mk;
    chk(rsp_status == (bad ? 2'd1 : ab ? 2'd2 : 2'd0), "R4/R7/R9 status",
        32'(rsp_status), bad ? 32'd1 : ab ? 32'd2 : 32'd0);
    chk(rsp_rdata == edata, wr ? "R7 write data" : "R6 read data", rsp_rdata, edata);
    chk(scnt - base == ns, "R8 strobe count", 32'(scnt - base), 32'(ns));
    chk(!abort_flag, "R7 abort cleared", {31'd0, abort_flag}, 32'd0);
    if (!bad) begin
      chk(cap_addr == ea, b == 0 ? "R1 type0 address" : "R2 type1 address", cap_addr, ea);
      chk(cap_cmd == {exp_be(n, int'(sz)), wr ? 4'hB : 4'hA}, "R3 command", 32'(cap_cmd),
          32'({exp_be(n, int'(sz)), wr ? 4'hB : 4'hA}));
      if (wr) chk(cap_wd == (wd << (8 * n)), "R5 write lanes", cap_wd, wd << (8 * n));
      chk(!drift, "R10 command stable", {31'd0, drift}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    seen_rsp = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !rsp_valid && !bus_strobe, "R9 reset state",
        {28'd0, req_ready, busy, rsp_valid, bus_strobe}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R9 idle after reset", {30'd0, req_ready, busy}, 32'h2);
    do_txn(8'd0, 5'd1, 3'd2, 8'h10, 3'd4, 1'b0, 32'd0, 1'b0);
    do_txn(8'd0, 5'd0, 3'd1, 8'h3c, 3'd1, 1'b0, 32'd0, 1'b0);
    do_txn(8'hab, 5'd31, 3'd7, 8'hff, 3'd1, 1'b0, 32'd0, 1'b0);
    do_txn(8'h01, 5'd3, 3'd0, 8'h06, 3'd2, 1'b0, 32'd0, 1'b0);
    do_txn(8'h01, 5'd3, 3'd0, 8'h07, 3'd2, 1'b0, 32'd0, 1'b0);
    do_txn(8'h00, 5'd4, 3'd0, 8'h04, 3'd3, 1'b1, 32'h55, 1'b0);
    do_txn(8'h00, 5'd4, 3'd0, 8'h04, 3'd0, 1'b0, 32'h0, 1'b1);
    do_txn(8'h02, 5'd9, 3'd5, 8'h22, 3'd2, 1'b1, 32'hbeef, 1'b0);
    do_txn(8'h00, 5'd21, 3'd0, 8'h01, 3'd1, 1'b1, 32'h7a, 1'b1);
    do_txn(8'h00, 5'd7, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, 1'b0);
    do_txn(8'h05, 5'd19, 3'd1, 8'h08, 3'd4, 1'b1, 32'h1234_5678, 1'b0);
    do_txn(8'h00, 5'd12, 3'd3, 8'h2d, 3'd1, 1'b0, 32'h0, 1'b1);
    do_txn(8'h00, 5'd7, 3'd3, 8'h2e, 3'd2, 1'b0, 32'h0, 1'b1);
    do_txn(8'h00, 5'd10, 3'd0, 8'h0c, 3'd4, 1'b0, 32'h0, 1'b0);
    for (int k = 0; k < 200; k++) begin
      logic [7:0] b;
      logic [4:0] d;
      logic [2:0] sz;
      int p;
      b  = ($urandom % 2) ? 8'd0 : 8'($urandom);
      d  = (b == 0) ? 5'(1 + $urandom % 21) : 5'($urandom);
      p  = $urandom % 10;
      sz = (p < 3) ? 3'd1 : (p < 6) ? 3'd2 : (p < 9) ? 3'd4 : 3'($urandom);
      do_txn(b, d, 3'($urandom), 8'($urandom), sz, 1'($urandom), $urandom, 1'($urandom));
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule